// File: doc/BRIEF.md
# Indirect Pointer Address Unit

This block holds two 16-bit indirect pointers and forms the effective address for every indirect load or store a processor core issues. One command per cycle selects a pointer and an operation. The operation either loads one byte of the pointer, adds a small signed immediate to it, or performs an indirect access. An access can be plain, pre-increment, pre-decrement, post-increment, post-decrement, or a signed offset from the pointer. The effective address is combinational from the command and the current pointer value. Any pointer update takes effect at the next clock edge.

Each access address is also classified into a region, and the physical address inside that region is produced. The regions are:
- the banked register file;
- a linear window that strings the 80-byte general-purpose block of each bank into one contiguous array;
- program memory, selected by the top address bit;
- unmapped space.

The memories themselves and the instruction decoder sit outside this block.

Top module: `iptr_unit`

## Requirements
- R1: While reset is asserted and after it is released, both pointers read 0x0000 and `accValid` is low.
- R2: Byte load commands replace one byte of the selected pointer with `wrData`: op 3 loads bits 7:0 and op 4 loads bits 15:8. The other byte and the other pointer are unchanged.
- R3: An access (op 1) in plain mode (mode 0) presents the selected pointer as `effAddr` with `accValid` high, and leaves the pointer unchanged.
- R4: Pre-increment (mode 1) and pre-decrement (mode 2) present the pointer plus or minus one as `effAddr`, and write that value back to the pointer at the clock edge.
- R5: Post-increment (mode 3) and post-decrement (mode 4) present the old pointer as `effAddr`, then write the old pointer plus or minus one back to the pointer.
- R6: Offset mode (mode 5) presents the pointer plus the sign-extended 6-bit two's-complement `imm` (range -32..+31) as `effAddr`, and leaves the pointer unchanged.
- R7: Adjust (op 2) adds the sign-extended `imm` to the selected pointer and keeps `accValid` low.
- R8: All pointer and address arithmetic wraps modulo 2^16.
- R9: An access address with bit 15 set reports region 2 (program), with `progAddr` equal to address bits 14:0 and `dataAddr` zero.
- R10: An access address from 0x0000 to 0x0FFF reports region 0 (banked), with `dataAddr` equal to address bits 11:0.
- R11: An access address from 0x2000 to 0x29FF reports region 1 (linear). With n = address - 0x2000, `dataAddr` is (n/80)*128 + 0x20 + (n mod 80).
- R12: Any other address reports region 3 (unmapped), with `dataAddr` and `progAddr` zero.
- R13: With `cmdValid` low, or with op 0, nothing changes and `accValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command present this cycle |
| cmdOp | input | 3 | 0 idle, 1 access, 2 adjust, 3 load low byte, 4 load high byte |
| accMode | input | 3 | 0 plain, 1 pre-inc, 2 pre-dec, 3 post-inc, 4 post-dec, 5 offset |
| ptrSel | input | 1 | Pointer selected by the command |
| imm | input | 6 | Signed offset or adjust value |
| wrData | input | 8 | Byte for load commands |
| accValid | output | 1 | An access address is presented |
| effAddr | output | 16 | Effective address of the access |
| region | output | 2 | 0 banked, 1 linear, 2 program, 3 unmapped |
| dataAddr | output | 12 | Physical data-memory address (bank*128 + offset) |
| progAddr | output | 15 | Program-memory word address |
| ptr0 | output | 16 | Current value of pointer 0 |
| ptr1 | output | 16 | Current value of pointer 1 |

## Verification
Random command streams mix every access mode with adjusts and byte loads. The high-byte loads are biased so that pointers land in each region. This separates the use of the old versus the new pointer, and it catches cross-talk between the two pointers. Directed vectors cover the following:
- the region edges 0x0FFF/0x1000, 0x1FFF/0x2000 and 0x29FF/0x2A00, and 0x7FFF/0x8000;
- increments and decrements across 0xFFFF/0x0000;
- offsets of -32 and +31.

These expose off-by-one region limits, a wrong sign extension, and a broken bank/offset split in the linear window.

// File: rtl/iptr_pkg.sv
package iptr_pkg;
  localparam int PTR_W = 16;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_ACCESS  = 3'd1,
    OP_ADJUST  = 3'd2,
    OP_LOAD_LO = 3'd3,
    OP_LOAD_HI = 3'd4
  } ptrOp_e;

  typedef enum logic [2:0] {
    AM_PLAIN    = 3'd0,
    AM_PRE_INC  = 3'd1,
    AM_PRE_DEC  = 3'd2,
    AM_POST_INC = 3'd3,
    AM_POST_DEC = 3'd4,
    AM_OFFSET   = 3'd5
  } accMode_e;

  typedef enum logic [1:0] {
    RG_BANKED   = 2'd0,
    RG_LINEAR   = 2'd1,
    RG_PROGRAM  = 2'd2,
    RG_UNMAPPED = 2'd3
  } region_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             accEn;   // present an access address
    logic             updEn;   // write adder result back
    logic             sel;     // pointer index
    logic             useNew;  // address from adder, not from old pointer
    logic [PTR_W-1:0] delta;   // adder operand
    logic             wrLo;    // byte load, low half
    logic             wrHi;    // byte load, high half
  } ptrStrobe_t;
endpackage

// File: rtl/iptr_ctrl.sv
module iptr_ctrl
  import iptr_pkg::*;
#(
  parameter int IMM_W = 6
) (
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  input  logic [2:0]       accMode,
  input  logic             ptrSel,
  input  logic [IMM_W-1:0] imm,
  output ptrStrobe_t       strobe
);
  localparam int EXT_W = PTR_W - IMM_W;

  logic [PTR_W-1:0] immExt;
  ptrOp_e           opDec;
  accMode_e         modeDec;

  assign immExt  = {{EXT_W{imm[IMM_W-1]}}, imm};
  assign opDec   = ptrOp_e'(cmdOp);
  assign modeDec = accMode_e'(accMode);

  always_comb begin
    strobe     = '0;
    strobe.sel = ptrSel;
    if (cmdValid) begin
      case (opDec)
        OP_ACCESS: begin
          strobe.accEn = 1'b1;
          case (modeDec)
            AM_PRE_INC: begin
              strobe.updEn = 1'b1; strobe.useNew = 1'b1; strobe.delta = PTR_W'(1);
            end
            AM_PRE_DEC: begin
              strobe.updEn = 1'b1; strobe.useNew = 1'b1; strobe.delta = '1;
            end
            AM_POST_INC: begin
              strobe.updEn = 1'b1; strobe.delta = PTR_W'(1);
            end
            AM_POST_DEC: begin
              strobe.updEn = 1'b1; strobe.delta = '1;
            end
            AM_OFFSET: begin
              strobe.useNew = 1'b1; strobe.delta = immExt;
            end
            default: ;
          endcase
        end
        OP_ADJUST: begin
          strobe.updEn = 1'b1;
          strobe.delta = immExt;
        end
        OP_LOAD_LO: strobe.wrLo = 1'b1;
        OP_LOAD_HI: strobe.wrHi = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/iptr_datapath.sv
module iptr_datapath
  import iptr_pkg::*;
#(
  parameter int          NUM_PTRS   = 2,
  parameter logic [15:0] BANK_LIMIT = 16'h1000,
  parameter logic [15:0] LIN_BASE   = 16'h2000,
  parameter int          GPR_BYTES  = 80,
  parameter int          GPR_START  = 32,
  parameter int          LIN_BANKS  = 32,
  localparam int         BANK_W     = $clog2(LIN_BANKS),
  localparam int         DADDR_W    = BANK_W + 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  ptrStrobe_t         strobe,
  input  logic [7:0]         wrData,
  output logic               accValid,
  output logic [PTR_W-1:0]   effAddr,
  output logic [1:0]         region,
  output logic [DADDR_W-1:0] dataAddr,
  output logic [PTR_W-2:0]   progAddr,
  output logic [PTR_W-1:0]   ptrVal [NUM_PTRS]
);
  localparam logic [15:0] LIN_SIZE = 16'(GPR_BYTES * LIN_BANKS);
  localparam logic [15:0] SPAN16   = 16'(GPR_BYTES);
  localparam logic [6:0]  GPR_OFS  = 7'(GPR_START);

  logic [PTR_W-1:0] ptrQ [NUM_PTRS];
  logic [PTR_W-1:0] curPtr, sumPtr;
  logic [15:0]      linOff, linBank, linIdx;
  region_e          regDec;

  for (genvar i = 0; i < NUM_PTRS; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ptrQ[i] <= '0;
      end else if (int'(strobe.sel) == i) begin
        if (strobe.updEn)     ptrQ[i]       <= sumPtr;
        else if (strobe.wrLo) ptrQ[i][7:0]  <= wrData;
        else if (strobe.wrHi) ptrQ[i][15:8] <= wrData;
      end
    end
    assign ptrVal[i] = ptrQ[i];
  end

  assign curPtr  = ptrQ[strobe.sel];
  assign sumPtr  = curPtr + strobe.delta;
  assign effAddr = strobe.useNew ? sumPtr : curPtr;
  assign accValid = strobe.accEn;

  // linear window split into bank index and in-bank byte
  assign linOff  = effAddr - LIN_BASE;
  assign linBank = linOff / SPAN16;
  assign linIdx  = linOff % SPAN16;

  always_comb begin
    regDec   = RG_UNMAPPED;
    dataAddr = '0;
    progAddr = '0;
    if (effAddr[PTR_W-1]) begin
      regDec   = RG_PROGRAM;
      progAddr = effAddr[PTR_W-2:0];
    end else if (effAddr < BANK_LIMIT) begin
      regDec   = RG_BANKED;
      dataAddr = effAddr[DADDR_W-1:0];
    end else if (effAddr >= LIN_BASE && linOff < LIN_SIZE) begin
      regDec   = RG_LINEAR;
      dataAddr = {linBank[BANK_W-1:0], GPR_OFS + linIdx[6:0]};
    end
  end

  assign region = regDec;
endmodule

// File: rtl/iptr_unit.sv
module iptr_unit
  import iptr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  input  logic [2:0]  cmdOp,
  input  logic [2:0]  accMode,
  input  logic        ptrSel,
  input  logic [5:0]  imm,
  input  logic [7:0]  wrData,
  output logic        accValid,
  output logic [15:0] effAddr,
  output logic [1:0]  region,
  output logic [11:0] dataAddr,
  output logic [14:0] progAddr,
  output logic [15:0] ptr0,
  output logic [15:0] ptr1
);
  ptrStrobe_t  strobe;
  logic [15:0] ptrVal [2];

  iptr_ctrl #(.IMM_W(6)) u_ctrl (
    .cmdValid(cmdValid), .cmdOp(cmdOp), .accMode(accMode),
    .ptrSel(ptrSel), .imm(imm), .strobe(strobe)
  );

  iptr_datapath #(.NUM_PTRS(2), .LIN_BANKS(32)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .wrData(wrData),
    .accValid(accValid), .effAddr(effAddr), .region(region),
    .dataAddr(dataAddr), .progAddr(progAddr), .ptrVal(ptrVal)
  );

  assign ptr0 = ptrVal[0];
  assign ptr1 = ptrVal[1];
endmodule

// File: rtl/iptr_unit_chk.sv
module iptr_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmdValid,
  input logic [2:0]  cmdOp,
  input logic [2:0]  accMode,
  input logic        ptrSel,
  input logic [5:0]  imm,
  input logic [7:0]  wrData,
  input logic        accValid,
  input logic [15:0] effAddr,
  input logic [1:0]  region,
  input logic [11:0] dataAddr,
  input logic [14:0] progAddr,
  input logic [15:0] ptr0,
  input logic [15:0] ptr1
);
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |=> $stable(ptr0) && $stable(ptr1)); // R13
  AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    !cmdValid |-> !accValid); // R13
  AST_PROG_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    accValid && effAddr[15] |-> region == 2'd2 && progAddr == effAddr[14:0]); // R9
  AST_BANK_REGION: assert property (@(posedge clk) disable iff (!rst_n)
    accValid && effAddr < 16'h1000 |-> region == 2'd0 && dataAddr == effAddr[11:0]); // R10
  AST_LIN_INBANK: assert property (@(posedge clk) disable iff (!rst_n)
    accValid && region == 2'd1 |-> dataAddr[6:0] >= 7'h20 && dataAddr[6:0] < 7'h70); // R11
  AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdOp == 3'd1 && accMode == 3'd5 && !ptrSel |=> $stable(ptr0)); // R6
  AST_POST_INC: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdOp == 3'd1 && accMode == 3'd3 && ptrSel |=> ptr1 == $past(ptr1) + 16'd1); // R5
  AST_ADJ_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    cmdValid && cmdOp == 3'd2 |-> !accValid); // R7
endmodule

bind iptr_unit iptr_unit_chk u_chk (.*);

// File: tb/iptr_unit_tb.sv
module iptr_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [2:0]  accMode = '0;
  logic        ptrSel = 1'b0;
  logic [5:0]  imm = '0;
  logic [7:0]  wrData = '0;
  logic        accValid;
  logic [15:0] effAddr;
  logic [1:0]  region;
  logic [11:0] dataAddr;
  logic [14:0] progAddr;
  logic [15:0] ptr0, ptr1;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  logic [15:0] mPtr [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  iptr_unit u_dut (.*);

  task automatic check(string tag, string what, longint act, longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sext(logic [5:0] v);
    return {{10{v[5]}}, v};
  endfunction

  function automatic logic [1:0] expRegion(logic [15:0] a);
    if (a[15]) return 2'd2;
    if (a <= 16'h0FFF) return 2'd0;
    if (a >= 16'h2000 && a <= 16'h29FF) return 2'd1;
    return 2'd3;
  endfunction

  function automatic logic [11:0] expData(logic [15:0] a);
    int n;
    case (expRegion(a))
      2'd0: return a[11:0];
      2'd1: begin
        n = int'(a) - 'h2000;
        return 12'((n / 80) * 128 + 32 + (n % 80));
      end
      default: return 12'd0;
    endcase
  endfunction

  function automatic string regionTag(logic [15:0] a);
    case (expRegion(a))
      2'd0: return "R10";
      2'd1: return "R11";
      2'd2: return "R9";
      default: return "R12";
    endcase
  endfunction

  function automatic string opTag(int op, int mode);
    if (op == 1) begin
      case (mode)
        0: return "R3";
        1, 2: return "R4";
        3, 4: return "R5";
        default: return "R6";
      endcase
    end
    if (op == 2) return "R7";
    if (op == 3 || op == 4) return "R2";
    return "R13";
  endfunction

  // apply one command: check the combinational outputs before the edge,
  // then the pointers after it
  task automatic apply(bit v, int op, int mode, bit sel, logic [5:0] k, logic [7:0] d,
                       string tagOverride = "");
    logic [15:0] old, nxt, eff;
    bit acc;
    string tg;
    @(negedge clk);
    cmdValid = v; cmdOp = 3'(op); accMode = 3'(mode); ptrSel = sel; imm = k; wrData = d;
    #1;
    old = mPtr[sel];
    nxt = old; eff = old; acc = 1'b0;
    if (v) begin
      case (op)
        1: begin
          acc = 1'b1;
          case (mode)
            1: begin nxt = old + 16'd1; eff = nxt; end
            2: begin nxt = old - 16'd1; eff = nxt; end
            3: nxt = old + 16'd1;
            4: nxt = old - 16'd1;
            5: eff = old + sext(k);
            default: ;
          endcase
        end
        2: nxt = old + sext(k);
        3: nxt = {old[15:8], d};
        4: nxt = {d, old[7:0]};
        default: ;
      endcase
    end
    tg = (tagOverride != "") ? tagOverride : (v ? opTag(op, mode) : "R13");
    check(tg, "accValid", accValid, acc);
    if (acc) begin
      check(tg, "effAddr", effAddr, eff);
      check(regionTag(eff), "region", region, expRegion(eff));
      check(regionTag(eff), "dataAddr", dataAddr, expData(eff));
      check(regionTag(eff), "progAddr", progAddr, eff[15] ? eff[14:0] : 15'd0);
    end
    @(posedge clk);
    mPtr[sel] = nxt;
    #1;
    check(tg, "ptr0", ptr0, mPtr[0]);
    check(tg, "ptr1", ptr1, mPtr[1]);
  endtask

  task automatic setPtr(bit sel, logic [15:0] val);
    apply(1'b1, 3, 0, sel, 6'd0, val[7:0]);
    apply(1'b1, 4, 0, sel, 6'd0, val[15:8]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    mPtr[0] = '0; mPtr[1] = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "ptr0 in reset", ptr0, 0);
    check("R1", "ptr1 in reset", ptr1, 0);
    check("R1", "accValid in reset", accValid, 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1", "ptr0 after reset", ptr0, 0);
    check("R1", "ptr1 after reset", ptr1, 0);

    // R2: byte loads keep the other byte and other pointer
    setPtr(1'b0, 16'h1234);
    setPtr(1'b1, 16'hABCD);
    apply(1'b1, 3, 0, 1'b0, 6'd0, 8'h55, "R2");
    // R13: invalid command and idle op have no effect
    apply(1'b0, 2, 0, 1'b0, 6'h1F, 8'hFF, "R13");
    apply(1'b1, 0, 3, 1'b1, 6'h01, 8'h77, "R13");

    // R8: wrap in both directions
    setPtr(1'b0, 16'hFFFF);
    apply(1'b1, 1, 1, 1'b0, 6'd0, 8'd0, "R8");
    apply(1'b1, 1, 4, 1'b0, 6'd0, 8'd0, "R8");
    apply(1'b1, 1, 2, 1'b0, 6'd0, 8'd0, "R8");
    apply(1'b1, 1, 3, 1'b0, 6'd0, 8'd0, "R8");
    setPtr(1'b1, 16'h0005);
    apply(1'b1, 1, 5, 1'b1, 6'h20, 8'd0, "R8");   // 5 - 32 wraps
    apply(1'b1, 2, 0, 1'b1, 6'h20, 8'd0, "R8");

    // R6 offset extremes
    setPtr(1'b0, 16'h2040);
    apply(1'b1, 1, 5, 1'b0, 6'h1F, 8'd0, "R6");
    apply(1'b1, 1, 5, 1'b0, 6'h20, 8'd0, "R6");

    // region edges
    setPtr(1'b0, 16'h0FFF); apply(1'b1, 1, 0, 1'b0, 6'd0, 8'd0, "R10");
    apply(1'b1, 1, 1, 1'b0, 6'd0, 8'd0, "R12");          // 0x1000
    setPtr(1'b0, 16'h1FFF); apply(1'b1, 1, 0, 1'b0, 6'd0, 8'd0, "R12");
    apply(1'b1, 1, 1, 1'b0, 6'd0, 8'd0, "R11");          // 0x2000
    setPtr(1'b0, 16'h204F); apply(1'b1, 1, 3, 1'b0, 6'd0, 8'd0, "R11");
    apply(1'b1, 1, 0, 1'b0, 6'd0, 8'd0, "R11");          // 0x2050, next bank
    setPtr(1'b0, 16'h29FF); apply(1'b1, 1, 0, 1'b0, 6'd0, 8'd0, "R11");
    apply(1'b1, 1, 1, 1'b0, 6'd0, 8'd0, "R12");          // 0x2A00
    setPtr(1'b1, 16'h7FFF); apply(1'b1, 1, 0, 1'b1, 6'd0, 8'd0, "R12");
    apply(1'b1, 1, 1, 1'b1, 6'd0, 8'd0, "R9");           // 0x8000

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      int r, op, mode;
      logic [7:0] d;
      r = int'($urandom_range(0, 99));
      if (r < 50) op = 1;
      else if (r < 65) op = 2;
      else if (r < 75) op = 3;
      else if (r < 88) op = 4;
      else op = 0;
      mode = int'($urandom_range(0, 5));
      d = 8'($urandom);
      if (op == 4) begin
        case ($urandom_range(0, 4))
          0: d = 8'($urandom_range(0, 15));
          1: d = 8'($urandom_range(16'h20, 16'h2A));
          2: d = 8'($urandom_range(16'h80, 16'hFF));
          3: d = 8'($urandom_range(16'h10, 16'h1F));
          default: ;
        endcase
      end
      apply(($urandom_range(0, 9) != 0), op, mode, 1'($urandom), 6'($urandom), d);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule